// File: doc/BRIEF.md
# Current-Loop DAC SPI Register Slave

This block is the device side of a serial link to a 16-bit current-output converter. A host sends 24-bit frames, most significant bit first, while holding chip select low. Each frame carries a read flag in bit 23, a 7-bit register address in bits 22:16 and a 16-bit payload in bits 15:0. Writes update the code, control, calibration offset and calibration gain registers, or trigger commands: load the active output code, return to defaults, or do nothing. A read is split over two frames. The first frame names the register. The 16-bit answer comes back on MISO in the low 16 bits of the frame that follows.

The serial pins are sampled through synchronisers on the system clock, so SCLK must be slow compared with `clk`. A fault status word combines a sticky serial-error flag with seven live fault conditions supplied from outside. A fault pin is raised whenever any of the five serious fault bits is set, and it cannot be masked. The active converter code is presented on `dac_code`.

Top module: `spi_cldac`

## Requirements
- R1: Frames are 24 bits, MSB first, sampled on SCLK rising edges. A write frame (bit 23 = 0) to address 1 stores the payload as the code register, and a later read of address 1 returns it.
- R2: A read frame (bit 23 = 1) makes the next frame shift out 8 zero bits followed by the 16-bit register value, MSB first. MISO changes after SCLK falling edges. In any frame not preceded by a valid read, MISO is 0 for all bits.
- R3: Address 2 (control) keeps only bits 12, 11, 9, 8, 7 and 6 of a write, which is the mask 0x1BC0. The other bits read back as 0.
- R4: `dac_code` changes only on a write to address 5, which copies the code register into it, or on a write to address 7. A write to address 1 alone leaves `dac_code` unchanged.
- R5: A read of address 5 returns the fault word. Bit 15 is the serial-error flag, and bits 14..8 are `fault_cond[6:0]` (packet error, over-current, under-current, above 140 C, above 100 C, supply below 6 V, supply below 12 V). Bits 7..0 are 0.
- R6: `fault_o` is high exactly when any of fault-word bits 15..11 is set, one clock after the condition input changes. Bits 10..8 never raise it.
- R7: A frame whose SCLK count at chip-select release is not 24 sets fault bit 15 and changes nothing else. The bit stays set until a read of address 5 reports it, and is then cleared.
- R8: A write to address 7 restores the defaults: code 0, control 0, offset 0x8000, gain 0xFFFF, `dac_code` 0, and fault bit 15 cleared.
- R9: Writes to addresses 0, 6, 8, 9 and 10..127 change no register. Reads of those addresses return 0x0000.
- R10: After reset, `dac_code` = 0, `fault_o` = 0, MISO = 0, offset = 0x8000, gain = 0xFFFF, control = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| mosi | input | 1 | Serial data from the host |
| fault_cond | input | 7 | Live fault conditions, mapped to fault bits 14..8 |
| miso | output | 1 | Serial data to the host |
| fault_o | output | 1 | Unmaskable fault pin |
| dac_code | output | 16 | Active converter code |

## Verification
The hardest situation to reach is the sticky serial-error flag interacting with the two-frame read. A short frame must set the flag. A following fault read must report it, and the read after that must show it gone, all while the live conditions drive other bits of the same word. Directed sequences create truncated frames and back-to-back fault reads. The random phase mixes short and over-long frames, read and write traffic, and changing fault conditions. Every returned word is compared with a bench model that also tracks which frame carries the pending answer.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int FRAME_W = 24;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 7;
    localparam int COND_W  = 7;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;
    localparam int PAD_W   = FRAME_W - DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        AD_CODE  = 7'd1,
        AD_CTRL  = 7'd2,
        AD_OFFS  = 7'd3,
        AD_GAIN  = 7'd4,
        AD_LOAD  = 7'd5,
        AD_ALARM = 7'd6,
        AD_DFLT  = 7'd7,
        AD_CONV  = 7'd8,
        AD_IDLE  = 7'd9
    } addr_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam logic [DATA_W-1:0] CTRL_KEEP = 16'h1BC0;
    localparam logic [DATA_W-1:0] OFFS_DEF  = 16'h8000;
    localparam logic [DATA_W-1:0] GAIN_DEF  = 16'hFFFF;

    function automatic logic pin_level(input logic [DATA_W-1:0] status);
        return |status[15:11];
    endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdac_link.sv
module sdac_link
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_en,
    output logic              frame_start,
    output logic              frame_ok,
    output logic              frame_bad,
    output frame_t            frame_q,
    output logic              miso
);
    logic               sclk_d, csn_d, active;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx_sh, tx_sh;

    wire sclk_rise = sclk_s & ~sclk_d;
    wire sclk_fall = ~sclk_s & sclk_d;
    wire cs_fall   = csn_d & ~csn_s;
    wire cs_rise   = ~csn_d & csn_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d      <= 1'b0;
            csn_d       <= 1'b1;
            active      <= 1'b0;
            cnt         <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            frame_start <= 1'b0;
            frame_ok    <= 1'b0;
            frame_bad   <= 1'b0;
        end else begin
            sclk_d      <= sclk_s;
            csn_d       <= csn_s;
            frame_start <= 1'b0;
            frame_ok    <= 1'b0;
            frame_bad   <= 1'b0;
            if (cs_fall) begin
                active      <= 1'b1;
                cnt         <= '0;
                tx_sh       <= tx_en ? {{PAD_W{1'b0}}, tx_word} : '0;
                frame_start <= 1'b1;
            end else if (active) begin
                if (cs_rise) begin
                    active <= 1'b0;
                    if (cnt == CNT_W'(FRAME_W)) frame_ok  <= 1'b1;
                    else                        frame_bad <= 1'b1;
                end else begin
                    if (sclk_rise) begin
                        rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
                        if (cnt != {CNT_W{1'b1}}) cnt <= cnt + 1'b1;
                    end
                    if (sclk_fall) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    assign frame_q = frame_t'(rx_sh);
    assign miso    = active & tx_sh[FRAME_W-1];
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_ok,
    input  logic              frame_bad,
    input  frame_t            frame_q,
    input  logic [COND_W-1:0] fault_cond,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [DATA_W-1:0] dac_code,
    output logic              fault_o
);
    logic [DATA_W-1:0] code_r, ctrl_r, offs_r, gain_r, status, rd_mux;
    logic [COND_W-1:0] cond_q;
    logic              serr;

    assign status = {serr, cond_q, {(DATA_W-COND_W-1){1'b0}}};

    always_comb begin
        case (frame_q.addr)
            AD_CODE: rd_mux = code_r;
            AD_CTRL: rd_mux = ctrl_r;
            AD_OFFS: rd_mux = offs_r;
            AD_GAIN: rd_mux = gain_r;
            AD_LOAD: rd_mux = status;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_r   <= '0;
            ctrl_r   <= '0;
            offs_r   <= OFFS_DEF;
            gain_r   <= GAIN_DEF;
            dac_code <= '0;
            serr     <= 1'b0;
            cond_q   <= '0;
            rd_word  <= '0;
            rd_valid <= 1'b0;
        end else begin
            cond_q <= fault_cond;
            if (frame_start) rd_valid <= 1'b0;
            if (frame_bad) serr <= 1'b1;
            if (frame_ok) begin
                if (frame_q.rd) begin
                    rd_word  <= rd_mux;
                    rd_valid <= 1'b1;
                    if (frame_q.addr == AD_LOAD) serr <= 1'b0;
                end else begin
                    case (frame_q.addr)
                        AD_CODE: code_r   <= frame_q.data;
                        AD_CTRL: ctrl_r   <= frame_q.data & CTRL_KEEP;
                        AD_OFFS: offs_r   <= frame_q.data;
                        AD_GAIN: gain_r   <= frame_q.data;
                        AD_LOAD: dac_code <= code_r;
                        AD_DFLT: begin
                            code_r   <= '0;
                            ctrl_r   <= '0;
                            offs_r   <= OFFS_DEF;
                            gain_r   <= GAIN_DEF;
                            dac_code <= '0;
                            serr     <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign fault_o = pin_level(status);
endmodule

// File: rtl/spi_cldac.sv
module spi_cldac
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [COND_W-1:0] fault_cond,
    output logic              miso,
    output logic              fault_o,
    output logic [DATA_W-1:0] dac_code
);
    logic              sclk_s, csn_s, mosi_s;
    logic              frame_start, frame_ok, frame_bad, rd_valid;
    logic [DATA_W-1:0] rd_word;
    frame_t            frame_q;

    sdac_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sclk (.clk(clk), .rst(rst), .d(sclk), .q(sclk_s));
    sdac_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_csn  (.clk(clk), .rst(rst), .d(cs_n), .q(csn_s));
    sdac_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_mosi (.clk(clk), .rst(rst), .d(mosi), .q(mosi_s));

    sdac_link u_link (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
        .tx_word(rd_word), .tx_en(rd_valid), .frame_start(frame_start),
        .frame_ok(frame_ok), .frame_bad(frame_bad), .frame_q(frame_q), .miso(miso)
    );

    sdac_regs u_regs (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_ok(frame_ok),
        .frame_bad(frame_bad), .frame_q(frame_q), .fault_cond(fault_cond),
        .rd_word(rd_word), .rd_valid(rd_valid), .dac_code(dac_code), .fault_o(fault_o)
    );
endmodule

// File: rtl/sdac_checker.sv
module sdac_checker
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [COND_W-1:0] fault_cond,
    input logic              fault_o,
    input logic [DATA_W-1:0] dac_code,
    input logic              frame_ok,
    input logic              frame_bad,
    input frame_t            frame_q
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_fault_pin_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(|fault_cond[6:3])) |-> fault_o);

    p_dac_cmd_only_r4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(dac_code)) |->
        $past(frame_ok && !frame_q.rd && (frame_q.addr == AD_LOAD || frame_q.addr == AD_DFLT)));

    p_bad_frame_err_r7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(frame_bad)) |-> fault_o);

    p_default_code_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(frame_ok && !frame_q.rd && frame_q.addr == AD_DFLT)) |-> (dac_code == '0));
endmodule

bind spi_cldac sdac_checker u_chk (
    .clk(clk), .rst(rst), .fault_cond(fault_cond), .fault_o(fault_o),
    .dac_code(dac_code), .frame_ok(frame_ok), .frame_bad(frame_bad), .frame_q(frame_q)
);

// File: tb/spi_cldac_test.sv
module spi_cldac_test;
    logic        clk = 0, rst = 1, sclk = 0, cs_n = 1, mosi = 0;
    logic [6:0]  fault_cond = '0;
    logic        miso, fault_o;
    logic [15:0] dac_code;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    localparam int HALF = 6;

    // bench model
    logic [15:0] m_code, m_ctrl, m_offs, m_gain, m_dac, pend_val;
    logic        m_serr, pend;

    always #4 clk = ~clk;

    spi_cldac uut (.clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .fault_cond(fault_cond), .miso(miso), .fault_o(fault_o), .dac_code(dac_code));

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [6:0] a);
        case (a)
            7'd1: return m_code;
            7'd2: return m_ctrl;
            7'd3: return m_offs;
            7'd4: return m_gain;
            7'd5: return {m_serr, fault_cond, 8'h00};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_pin();
        return m_serr | (|fault_cond[6:3]);
    endfunction

    task automatic model_reset();
        m_code = 0; m_ctrl = 0; m_offs = 16'h8000; m_gain = 16'hFFFF;
        m_dac = 0; m_serr = 0; pend = 0; pend_val = 0;
    endtask

    task automatic frame(input bit rd, input logic [6:0] a, input logic [15:0] d,
                         input int nbits, input string tag);
        logic [23:0] w, rx;
        bit had;
        logic [15:0] hv;
        w = {rd, a, d};
        rx = '0;
        had = pend; hv = pend_val;
        pend = 0;
        @(negedge clk); cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 24) rx[23-i] = miso;
            sclk = 1;
            repeat (HALF) @(negedge clk);
            sclk = 0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1;
        repeat (8) @(negedge clk);
        if (nbits == 24) begin
            check(rx == (had ? {8'h00, hv} : 24'h0), tag, "R2 MISO frame", rx, had ? {8'h00, hv} : 24'h0);
            if (rd) begin
                pend = 1; pend_val = model_read(a);
                if (a == 7'd5) m_serr = 0;
            end else begin
                case (a)
                    7'd1: m_code = d;
                    7'd2: m_ctrl = d & 16'h1BC0;
                    7'd3: m_offs = d;
                    7'd4: m_gain = d;
                    7'd5: m_dac = m_code;
                    7'd7: begin
                        m_code = 0; m_ctrl = 0; m_offs = 16'h8000; m_gain = 16'hFFFF;
                        m_dac = 0; m_serr = 0;
                    end
                    default: ;
                endcase
            end
        end else begin
            m_serr = 1;
        end
        check(dac_code == m_dac, "R4", "dac_code", dac_code, m_dac);
        check(fault_o == exp_pin(), "R6", "fault pin", fault_o, exp_pin());
    endtask

    // read address a, then verify in a following no-op frame
    task automatic read_chk(input logic [6:0] a, input logic [15:0] exp, input string tag);
        frame(1'b1, a, 16'h0, 24, tag);
        check(pend_val == exp, tag, "model readback", pend_val, exp);
        frame(1'b0, 7'd9, 16'h0, 24, tag);
    endtask

    task automatic set_cond(input logic [6:0] c);
        @(negedge clk); fault_cond = c;
        repeat (3) @(negedge clk);
        check(fault_o == exp_pin(), "R6", "pin after cond", fault_o, exp_pin());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(dac_code == 0, "R10", "dac after reset", dac_code, 0);
        check(fault_o == 0, "R10", "pin after reset", fault_o, 0);
        check(miso == 0, "R10", "miso after reset", miso, 0);
        read_chk(7'd4, 16'hFFFF, "R10");
        read_chk(7'd3, 16'h8000, "R10");
        read_chk(7'd2, 16'h0000, "R10");
        // R1 / R4
        frame(1'b0, 7'd1, 16'h1234, 24, "R1");
        check(dac_code == 0, "R4", "no load yet", dac_code, 0);
        read_chk(7'd1, 16'h1234, "R1");
        frame(1'b0, 7'd5, 16'h0, 24, "R4");
        check(dac_code == 16'h1234, "R4", "after load", dac_code, 16'h1234);
        // R3
        frame(1'b0, 7'd2, 16'hFFFF, 24, "R3");
        read_chk(7'd2, 16'h1BC0, "R3");
        // R9
        frame(1'b0, 7'd6, 16'hAAAA, 24, "R9");
        frame(1'b0, 7'd8, 16'h5555, 24, "R9");
        frame(1'b0, 7'd0, 16'h0F0F, 24, "R9");
        frame(1'b0, 7'd12, 16'hF0F0, 24, "R9");
        read_chk(7'd1, 16'h1234, "R9");
        read_chk(7'd2, 16'h1BC0, "R9");
        read_chk(7'd6, 16'h0000, "R9");
        read_chk(7'd9, 16'h0000, "R9");
        read_chk(7'd100, 16'h0000, "R9");
        // R5 / R6
        set_cond(7'b0000100);
        check(fault_o == 0, "R6", "bit10 no pin", fault_o, 0);
        read_chk(7'd5, 16'h0400, "R5");
        set_cond(7'b0001000);
        check(fault_o == 1, "R6", "bit11 pin", fault_o, 1);
        set_cond(7'b0000000);
        // R7
        frame(1'b0, 7'd1, 16'hBEEF, 20, "R7");
        check(fault_o == 1, "R7", "short frame pin", fault_o, 1);
        frame(1'b0, 7'd1, 16'hBEEF, 26, "R7");
        read_chk(7'd1, 16'h1234, "R7");
        read_chk(7'd5, 16'h8000, "R7");
        read_chk(7'd5, 16'h0000, "R7");
        // R8
        frame(1'b0, 7'd3, 16'h1111, 24, "R8");
        frame(1'b0, 7'd1, 16'h0, 10, "R8");
        frame(1'b0, 7'd7, 16'h0, 24, "R8");
        check(dac_code == 0, "R8", "dac after default", dac_code, 0);
        check(fault_o == 0, "R8", "pin after default", fault_o, 0);
        read_chk(7'd3, 16'h8000, "R8");
        read_chk(7'd4, 16'hFFFF, "R8");
        read_chk(7'd1, 16'h0000, "R8");
        // random phase
        for (int k = 0; k < 250; k++) begin
            int nb;
            if ($urandom_range(0, 9) == 0) set_cond(7'($urandom_range(0, 127)));
            nb = 24;
            if ($urandom_range(0, 19) == 0) begin
                nb = $urandom_range(1, 30);
                if (nb == 24) nb = 23;
            end
            frame($urandom_range(0, 2) == 0, 7'($urandom_range(0, 11)),
                  16'($urandom_range(0, 65535)), nb, "R1");
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule